// File: doc/BRIEF.md
# Multi-Level Adaptive Cache Insertion Controller

This block decides where a newly filled line enters the recency stack of a set-associative last-level cache and which way it replaces. For each access, the caller presents a set index, a hit flag and, on a hit, the way that hit. The tag compare and the data array stay outside the block. On a miss, the block returns at once the way to replace and whether the new line goes to the most-recent end of the stack or to the least-recent end. The bookkeeping for the set is written on the clock edge that ends the access.

Insertion is throttled by a level from 0 to 7. At level k, a fill goes to the most-recent end only when a free-running miss counter has its low k bits at zero. All other fills go to the least-recent end, so level 0 behaves as plain recency replacement. Three groups of sample sets run the level one below the current one, the current level and the level one above it. Each group keeps a saturating miss count. After every 1024 accesses, the group with the fewest misses sets the new current level, and the counts are cleared. The victim is chosen by a small per-line use counter, and recency breaks ties between lines with equal counts.

Top module: `adaptive_insert_ctrl`

## Requirements
- R1: After reset every way of every set is invalid, the per-way recency rank equals the way number (way 0 most recent) and `cur_level` is 0.
- R2: On a miss in a set that still has an invalid way, `resp_victim` is the lowest-numbered invalid way.
- R3: On a miss in a full set, `resp_victim` is the way with the smallest use count; among equal counts it is the way with the highest rank (closest to the least-recent end, rank 15).
- R4: A filled line starts with use count 0; each hit adds one, saturating at 3.
- R5: A hit gives the hit way rank 0 and adds one to every rank that was below the hit way's old rank.
- R6: A fill with `resp_mru`=1 gives the new line rank 0 and pushes smaller ranks up by one. With `resp_mru`=0, the new line gets rank 15 and larger ranks move down by one. `resp_mru` is 1 exactly when the low L bits of a 7-bit miss counter are zero, where L is the set's effective level. That counter starts at 0 and advances on every miss.
- R7: A set's class is taken from the low three index bits: value 0 runs level max(cur−1,0), value 1 runs the current level, value 2 runs level min(cur+1,7), and values 3 to 7 are followers that run the current level.
- R8: Each of the three sample classes keeps a 10-bit miss count that saturates at 1023 and counts only misses in that class.
- R9: On the 1024th valid access of each epoch, the counts including that access are compared. The lower level wins if its count is below the current level's count and not above the upper level's count. Otherwise the upper level wins if its count is below the current level's count. Otherwise the current level is kept. All counts are then cleared. `cur_level` changes at no other time.
- R10: `cur_level` never leaves 0..7; at an end of the range the missing neighbour's sample sets run the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_set | input | 8 | Set index of the access |
| req_hit | input | 1 | The access hit in the tag array |
| req_way | input | 4 | Way that hit (ignored on a miss) |
| resp_valid | output | 1 | A miss needs a fill this cycle |
| resp_victim | output | 4 | Way to replace |
| resp_mru | output | 1 | 1: insert at the most-recent end; 0: at the least-recent end |
| cur_level | output | 3 | Current throttle level |

## Verification
An epoch decision and a fill can coincide: the 1024th access of an epoch may itself be a miss in a sample set. That one access then updates a class count, advances the miss counter and moves the current level, all on the same edge. The bench provokes this by running long random miss streams that are weighted across the three sample classes, so epoch boundaries land on sample-set misses of every class. A behavioural model counts that access before it compares the classes. It then checks, on the next cycle, the new level and the insertion decision of the following fill.

// File: rtl/aci_pkg.sv
package aci_pkg;
   typedef enum logic [1:0] {
      CLS_FOLLOW = 2'd0,
      CLS_LOW    = 2'd1,
      CLS_CUR    = 2'd2,
      CLS_HIGH   = 2'd3
   } set_class_e;
endpackage

// File: rtl/aci_victim_pick.sv
module aci_victim_pick #(
   parameter int WAYS      = 16,
   parameter int WAY_W     = 4,
   parameter int FREQ_BITS = 2
) (
   input  logic [WAYS-1:0]                vld,
   input  logic [WAYS-1:0][WAY_W-1:0]     rnk,
   input  logic [WAYS-1:0][FREQ_BITS-1:0] frq,
   output logic [WAY_W-1:0]               victim
);
   logic                 have_inv;
   logic [WAY_W-1:0]     inv_way;
   logic [WAY_W-1:0]     best_way;
   logic [FREQ_BITS-1:0] best_f;
   logic [WAY_W-1:0]     best_r;

   // lowest invalid way: scan from the top so the last hit wins
   always_comb begin
      have_inv = 1'b0;
      inv_way  = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!vld[w]) begin
            have_inv = 1'b1;
            inv_way  = WAY_W'(w);
         end
      end
   end

   // least used line, ties to the deepest rank
   always_comb begin
      best_way = '0;
      best_f   = frq[0];
      best_r   = rnk[0];
      for (int w = 1; w < WAYS; w++) begin
         if (frq[w] < best_f || (frq[w] == best_f && rnk[w] > best_r)) begin
            best_way = WAY_W'(w);
            best_f   = frq[w];
            best_r   = rnk[w];
         end
      end
   end

   assign victim = have_inv ? inv_way : best_way;
endmodule

// File: rtl/aci_stack_update.sv
module aci_stack_update #(
   parameter int WAYS      = 16,
   parameter int WAY_W     = 4,
   parameter int FREQ_BITS = 2
) (
   input  logic [WAYS-1:0]                vld,
   input  logic [WAYS-1:0][WAY_W-1:0]     rnk,
   input  logic [WAYS-1:0][FREQ_BITS-1:0] frq,
   input  logic                           do_hit,
   input  logic                           do_fill,
   input  logic [WAY_W-1:0]               way,
   input  logic                           to_mru,
   output logic [WAYS-1:0]                nvld,
   output logic [WAYS-1:0][WAY_W-1:0]     nrnk,
   output logic [WAYS-1:0][FREQ_BITS-1:0] nfrq
);
   localparam logic [WAY_W-1:0] DEEPEST = WAY_W'(WAYS-1);

   logic [WAY_W-1:0] old_r;
   assign old_r = rnk[way];

   always_comb begin
      nvld = vld;
      nrnk = rnk;
      nfrq = frq;
      if (do_hit) begin
         for (int w = 0; w < WAYS; w++)
            if (rnk[w] < old_r) nrnk[w] = rnk[w] + 1'b1;
         nrnk[way] = '0;
         if (frq[way] != '1) nfrq[way] = frq[way] + 1'b1;
      end else if (do_fill) begin
         nvld[way] = 1'b1;
         nfrq[way] = '0;
         if (to_mru) begin
            for (int w = 0; w < WAYS; w++)
               if (rnk[w] < old_r) nrnk[w] = rnk[w] + 1'b1;
            nrnk[way] = '0;
         end else begin
            for (int w = 0; w < WAYS; w++)
               if (rnk[w] > old_r) nrnk[w] = rnk[w] - 1'b1;
            nrnk[way] = DEEPEST;
         end
      end
   end
endmodule

// File: rtl/aci_level_duel.sv
module aci_level_duel
   import aci_pkg::*;
#(
   parameter int LEVELS     = 8,
   parameter int LVL_W      = 3,
   parameter int CNT_BITS   = 10,
   parameter int EPOCH_BITS = 10,
   parameter int INIT_LEVEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             miss,
   input  set_class_e       cls,
   output logic [LVL_W-1:0] cur_level,
   output logic             to_mru
);
   localparam int THR_W = LEVELS - 1;
   localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS-1);

   logic [LVL_W-1:0]              cur_q, lvl_lo, lvl_hi, eff, pick;
   logic [THR_W-1:0]              thr_q, mask;
   logic [EPOCH_BITS-1:0]         ep_q;
   logic [2:0][CNT_BITS-1:0]      cnt_q, cnt_n;
   logic [2:0]                    inc;
   logic                          epoch_end;

   assign lvl_lo = (cur_q == '0)  ? cur_q : cur_q - 1'b1;
   assign lvl_hi = (cur_q == TOP) ? cur_q : cur_q + 1'b1;

   always_comb begin
      case (cls)
         CLS_LOW:  eff = lvl_lo;
         CLS_HIGH: eff = lvl_hi;
         default:  eff = cur_q;
      endcase
   end

   assign mask   = (THR_W'(1) << eff) - THR_W'(1);
   assign to_mru = (thr_q & mask) == '0;

   assign inc[0] = acc && miss && cls == CLS_LOW;
   assign inc[1] = acc && miss && cls == CLS_CUR;
   assign inc[2] = acc && miss && cls == CLS_HIGH;

   always_comb
      for (int i = 0; i < 3; i++)
         cnt_n[i] = (inc[i] && cnt_q[i] != '1) ? cnt_q[i] + 1'b1 : cnt_q[i];

   assign epoch_end = acc && ep_q == '1;

   always_comb begin
      if (cnt_n[0] < cnt_n[1] && cnt_n[0] <= cnt_n[2]) pick = lvl_lo;
      else if (cnt_n[2] < cnt_n[1])                     pick = lvl_hi;
      else                                               pick = cur_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= LVL_W'(INIT_LEVEL);
         thr_q <= '0;
         ep_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (acc && miss) thr_q <= thr_q + 1'b1;
         if (acc)         ep_q  <= ep_q + 1'b1;
         if (epoch_end) begin
            cur_q <= pick;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_n;
         end
      end
   end

   assign cur_level = cur_q;

   // R9: the level moves only on an epoch boundary
   p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch_end |=> $stable(cur_q));
   // R10: the level stays in range and steps by at most one
   p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      epoch_end |=> (cur_q <= TOP) &&
         (cur_q == $past(cur_q) || cur_q == $past(cur_q) + 1'b1 || cur_q + 1'b1 == $past(cur_q)));

   generate
      for (genvar g = 0; g < 3; g++) begin : g_cnt_chk
         // R8: a full count never wraps inside an epoch
         p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == '1 && !epoch_end) |=> cnt_q[g] == '1);
      end
   endgenerate
endmodule

// File: rtl/adaptive_insert_ctrl.sv
module adaptive_insert_ctrl
   import aci_pkg::*;
#(
   parameter int WAYS        = 16,
   parameter int SET_BITS    = 8,
   parameter int SAMPLE_BITS = 5,
   parameter int LEVELS      = 8,
   parameter int CNT_BITS    = 10,
   parameter int EPOCH_BITS  = 10,
   parameter int FREQ_BITS   = 2,
   parameter int INIT_LEVEL  = 0,
   localparam int WAY_W      = $clog2(WAYS),
   localparam int LVL_W      = $clog2(LEVELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [SET_BITS-1:0] req_set,
   input  logic                req_hit,
   input  logic [WAY_W-1:0]    req_way,
   output logic                resp_valid,
   output logic [WAY_W-1:0]    resp_victim,
   output logic                resp_mru,
   output logic [LVL_W-1:0]    cur_level
);
   localparam int SETS     = 1 << SET_BITS;
   localparam int SEL_BITS = SET_BITS - SAMPLE_BITS;

   generate
      if (SEL_BITS < 2) begin : g_bad_sel
         $error("set index too narrow for three sample classes");
      end
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("way count must be a power of two");
      end
      if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_bad_lvls
         $error("level count must be a power of two");
      end
      if (INIT_LEVEL >= LEVELS) begin : g_bad_init
         $error("initial level out of range");
      end
   endgenerate

   logic [WAYS-1:0]                vld_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0]     rnk_q [SETS];
   logic [WAYS-1:0][FREQ_BITS-1:0] frq_q [SETS];

   logic [WAYS-1:0]                vld_n;
   logic [WAYS-1:0][WAY_W-1:0]     rnk_n;
   logic [WAYS-1:0][FREQ_BITS-1:0] frq_n;

   logic [SEL_BITS-1:0] sel;
   set_class_e          cls;
   logic [WAY_W-1:0]    victim, upd_way;
   logic                ins_mru;
   logic                is_miss;

   assign sel     = req_set[SEL_BITS-1:0];
   assign is_miss = req_valid && !req_hit;

   always_comb begin
      case (sel)
         SEL_BITS'(0): cls = CLS_LOW;
         SEL_BITS'(1): cls = CLS_CUR;
         SEL_BITS'(2): cls = CLS_HIGH;
         default:      cls = CLS_FOLLOW;
      endcase
   end

   aci_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W), .FREQ_BITS(FREQ_BITS)) u_pick (
      .vld   (vld_q[req_set]),
      .rnk   (rnk_q[req_set]),
      .frq   (frq_q[req_set]),
      .victim(victim)
   );

   aci_level_duel #(
      .LEVELS(LEVELS), .LVL_W(LVL_W), .CNT_BITS(CNT_BITS),
      .EPOCH_BITS(EPOCH_BITS), .INIT_LEVEL(INIT_LEVEL)
   ) u_duel (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (req_valid),
      .miss     (!req_hit),
      .cls      (cls),
      .cur_level(cur_level),
      .to_mru   (ins_mru)
   );

   assign upd_way = req_hit ? req_way : victim;

   aci_stack_update #(.WAYS(WAYS), .WAY_W(WAY_W), .FREQ_BITS(FREQ_BITS)) u_upd (
      .vld    (vld_q[req_set]),
      .rnk    (rnk_q[req_set]),
      .frq    (frq_q[req_set]),
      .do_hit (req_valid && req_hit),
      .do_fill(is_miss),
      .way    (upd_way),
      .to_mru (ins_mru),
      .nvld   (vld_n),
      .nrnk   (rnk_n),
      .nfrq   (frq_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            frq_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) rnk_q[s][w] <= WAY_W'(w);
         end
      end else if (req_valid) begin
         vld_q[req_set] <= vld_n;
         rnk_q[req_set] <= rnk_n;
         frq_q[req_set] <= frq_n;
      end
   end

   assign resp_valid  = is_miss;
   assign resp_victim = victim;
   assign resp_mru    = ins_mru;

   // R2: a set with a free way never evicts a valid line
   p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !(&vld_q[req_set])) |-> !vld_q[req_set][resp_victim]);
   // R4: a fill leaves a valid line with a zero use count
   p_fill_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> vld_q[$past(req_set)][$past(resp_victim)] &&
                     frq_q[$past(req_set)][$past(resp_victim)] == '0);
   // R5: a hit leaves the line at the most-recent end with a non-zero count
   p_hit_front_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit) |=> rnk_q[$past(req_set)][$past(req_way)] == '0 &&
                                 frq_q[$past(req_set)][$past(req_way)] != '0);
   // R6: a fill at the least-recent end lands at the deepest rank
   p_tail_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_mru) |=> rnk_q[$past(req_set)][$past(resp_victim)] == WAY_W'(WAYS-1));
endmodule

// File: tb/adaptive_insert_ctrl_test.sv
`timescale 1ns/1ps
module adaptive_insert_ctrl_test;
   localparam int NSETS = 256;
   localparam int NWAYS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_set = '0;
   logic       req_hit = 1'b0;
   logic [3:0] req_way = '0;
   logic       resp_valid;
   logic [3:0] resp_victim;
   logic       resp_mru;
   logic [2:0] cur_level;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int mv [NSETS][NWAYS];
   int mr [NSETS][NWAYS];
   int mf [NSETS][NWAYS];
   int lvl, thr, ep;
   int mc [3];

   always #2.5 clk = ~clk;

   adaptive_insert_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
      .req_hit(req_hit), .req_way(req_way), .resp_valid(resp_valid),
      .resp_victim(resp_victim), .resp_mru(resp_mru), .cur_level(cur_level)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int eff_level(int s);
      int c = s % 8;
      if (c == 0) return (lvl > 0) ? lvl - 1 : 0;
      if (c == 2) return (lvl < 7) ? lvl + 1 : 7;
      return lvl;
   endfunction

   function automatic int exp_victim(int s);
      int b = 0;
      for (int w = 0; w < NWAYS; w++) if (mv[s][w] == 0) return w;
      for (int w = 1; w < NWAYS; w++)
         if (mf[s][w] < mf[s][b] || (mf[s][w] == mf[s][b] && mr[s][w] > mr[s][b])) b = w;
      return b;
   endfunction

   function automatic bit exp_mru(int s);
      int m = (1 << eff_level(s)) - 1;
      return (thr & m) == 0;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < NSETS; s++)
         for (int w = 0; w < NWAYS; w++) begin
            mv[s][w] = 0; mf[s][w] = 0; mr[s][w] = w;
         end
      lvl = 0; thr = 0; ep = 0;
      mc[0] = 0; mc[1] = 0; mc[2] = 0;
   endtask

   task automatic model_step(int s, bit h, int w, int v, bit top);
      int c = s % 8;
      if (h) begin
         int o = mr[s][w];
         for (int k = 0; k < NWAYS; k++) if (mr[s][k] < o) mr[s][k]++;
         mr[s][w] = 0;
         if (mf[s][w] < 3) mf[s][w]++;
      end else begin
         int o = mr[s][v];
         mv[s][v] = 1; mf[s][v] = 0;
         if (top) begin
            for (int k = 0; k < NWAYS; k++) if (mr[s][k] < o) mr[s][k]++;
            mr[s][v] = 0;
         end else begin
            for (int k = 0; k < NWAYS; k++) if (mr[s][k] > o) mr[s][k]--;
            mr[s][v] = 15;
         end
         thr = (thr + 1) % 128;
         if (c == 0 && mc[0] < 1023) mc[0]++;
         if (c == 1 && mc[1] < 1023) mc[1]++;
         if (c == 2 && mc[2] < 1023) mc[2]++;
      end
      if (ep == 1023) begin
         int lo = (lvl > 0) ? lvl - 1 : 0;
         int hi = (lvl < 7) ? lvl + 1 : 7;
         if (mc[0] < mc[1] && mc[0] <= mc[2]) lvl = lo;
         else if (mc[2] < mc[1])               lvl = hi;
         mc[0] = 0; mc[1] = 0; mc[2] = 0;
         ep = 0;
      end else ep++;
   endtask

   task automatic access(int s, bit h, int w, string tag);
      int  v;
      bit  top;
      @(negedge clk);
      req_valid = 1'b1; req_set = 8'(s); req_hit = h; req_way = 4'(w);
      #1;
      v = exp_victim(s);
      top = exp_mru(s);
      check(resp_valid == !h, tag, resp_valid, !h);
      if (!h) begin
         check(resp_victim == 4'(v), tag, resp_victim, v);
         check(resp_mru == top, {tag, " R6"}, resp_mru, top);
      end
      check(cur_level == 3'(lvl), {tag, " R9"}, cur_level, lvl);
      @(posedge clk);
      model_step(s, h, w, v, top);
   endtask

   task automatic miss_stream(int epochs, int wl, int wc, int wh, int wf, string tag);
      for (int n = 0; n < epochs * 1024; n++) begin
         int r = $urandom_range(wl + wc + wh + wf - 1);
         int c;
         if (r < wl)                c = 0;
         else if (r < wl + wc)      c = 1;
         else if (r < wl + wc + wh) c = 2;
         else                       c = 3 + $urandom_range(4);
         access(($urandom_range(31) << 3) | c, 1'b0, 0, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state seen at the ports
      check(cur_level == 3'd0, "R1 level", cur_level, 0);
      check(resp_valid == 1'b0, "R1 idle", resp_valid, 0);

      // R1 R2: empty set gives way 0, then fills in way order
      for (int i = 0; i < 16; i++) access(3, 1'b0, 0, "R2 fill");
      // R4 R5: hits reorder the stack and raise use counts
      for (int i = 0; i < 5; i++) access(3, 1'b1, 2, "R4 hit");
      access(3, 1'b1, 0, "R5 hit");
      access(3, 1'b1, 7, "R5 hit");
      access(3, 1'b1, 9, "R5 hit");
      // R3: full set victims by use count then depth
      for (int i = 0; i < 20; i++) access(3, 1'b0, 0, "R3 evict");
      access(3, 1'b1, 2, "R4 hit");
      for (int i = 0; i < 4; i++) access(3, 1'b0, 0, "R3 evict");
      // R2: partially filled follower set
      for (int i = 0; i < 3; i++) access(11, 1'b0, 0, "R2 partial");
      access(11, 1'b1, 1, "R5 hit");
      access(11, 1'b0, 0, "R2 partial");

      // R7 R9 R10: upper samples miss least, level climbs and clamps at 7
      miss_stream(10, 3, 3, 1, 1, "R7 climb");
      #1 check(cur_level == 3'd7, "R10 top clamp", cur_level, 7);
      // R7 R9 R10: lower samples miss least, level falls and clamps at 0
      miss_stream(10, 1, 3, 3, 1, "R7 fall");
      #1 check(cur_level == 3'd0, "R10 bottom clamp", cur_level, 0);
      // R9: no sample misses at all, ties keep the level
      miss_stream(2, 0, 0, 0, 1, "R9 tie");
      // R8: one class floods past its count limit
      miss_stream(2, 1, 0, 0, 0, "R8 flood");
      // R6: mid level throttling mixed with hits in a full set
      miss_stream(3, 3, 3, 1, 1, "R6 mix");
      for (int i = 0; i < 40; i++) access(3, 1'b1, i % 16, "R5 late hit");
      for (int i = 0; i < 40; i++) access(3, 1'b0, 0, "R3 late evict");

      @(negedge clk);
      req_valid = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule